// File: doc/BRIEF.md
# Programmable-Format Serial Character Receiver

This block takes an asynchronous serial line, clocked at sixteen times the bit rate, and rebuilds characters whose shape is set by a five-bit control word. The control word sets the number of data bits (5 to 8), whether a parity bit follows the data, the parity sense, and whether one or two stop bits close the frame. The host writes the control word by holding the control-load strobe high.

Each complete character is placed in an 8-bit receive buffer, least significant bit first as received. Bits above the selected length are zero. The data-ready flag and the three error flags (parity, framing, overrun) update on the same cycle as the buffer and then hold until the next character completes. The host acknowledges a character with the data-ready reset input. If a new character arrives before that acknowledgement, it still replaces the buffer, and the overrun flag records that the earlier character was lost.

Top module: `uart_frame_rx`

## Requirements
- R1: While reset is active and after it is released, with no character received, `rbuf`, `data_ready`, `par_err`, `frm_err` and `ovr_err` are all 0.
- R2: The control word is captured on every clock edge where `ctl_load` is 1. Changes on `ctl_word` while `ctl_load` is 0 have no effect. The fields are: [1:0] character length (00=5, 01=6, 10=7, 11=8 data bits); [2] stop bits (0 = one, 1 = two); [3] parity present; [4] parity sense (1 = even, 0 = odd).
- R3: A 0 seen on an idle line starts a frame only if the line is still 0 at the middle sample, 8 clocks later. A shorter low pulse is ignored and produces no character.
- R4: After an accepted start bit, each further bit is sampled once, 16 clocks after the previous sample. Data bits arrive least significant bit first and appear in `rbuf` in the same bit positions.
- R5: For lengths below 8, the unused high bits of `rbuf` are 0, whatever the line carried in the later bit slots.
- R6: `data_ready` goes to 1 when a character completes and goes to 0 after `dr_clr` is 1 on a clock edge. A completion in the same cycle as `dr_clr` wins.
- R7: When parity is present, `par_err` is 1 for a character whose parity bit does not give the selected parity over its data bits, and 0 otherwise. When parity is absent, `par_err` is 0.
- R8: `frm_err` is 1 for a character whose stop bit is 0. With two stop bits, a 0 in either stop position sets it.
- R9: `ovr_err` is 1 when a character completes while `data_ready` is still 1. `rbuf` then holds the new character. The next character that completes with `data_ready` at 0 clears `ovr_err`.
- R10: `rbuf` and the three error flags change only in the cycle a character completes, and all of them change together in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk16 | input | 1 | Receive clock, 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_in | input | 1 | Serial line, idle high |
| ctl_word | input | 5 | Format control word |
| ctl_load | input | 1 | Captures `ctl_word` while high |
| dr_clr | input | 1 | Data-ready acknowledge |
| rbuf | output | 8 | Received character, zero-padded |
| data_ready | output | 1 | Unread character present |
| par_err | output | 1 | Parity mismatch on last character |
| frm_err | output | 1 | Stop position read as 0 on last character |
| ovr_err | output | 1 | Last character arrived before acknowledgement |

## Verification
A bit counter or sample phase that is off by one shows up within one character: the buffer holds the data shifted by one place, or the framing flag is wrong, because the stop sample falls on a data bit. A wrong length, parity or stop decode in the latched format shows on the flags of the first character sent in that format, and wrong padding shows as stray high bits in the buffer. Errors in the flag-update logic show as data-ready or overrun values that disagree with the sequence of acknowledgements, seen by the second character.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  localparam int unsigned RX_OSR       = 16;
  localparam int unsigned RX_DATA_MAX  = 8;
  localparam int unsigned RX_DATA_MIN  = 5;
  localparam int unsigned RX_FRAME_MAX = RX_DATA_MAX + 3;
  localparam int unsigned RX_CFG_W     = 5;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_t;

  typedef struct packed {
    logic       even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] len;
  } rx_cfg_t;
endpackage

// File: rtl/rx_rst_sync.sv
`timescale 1ns/1ps
module rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/rx_cfg_latch.sv
`timescale 1ns/1ps
module rx_cfg_latch
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RX_CFG_W-1:0] ctl_word,
  input  logic                ctl_load,
  output rx_cfg_t             cfg
);
  rx_cfg_t cfg_q;
  rx_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (ctl_load) cfg_d = rx_cfg_t'(ctl_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/rx_bit_timer.sv
`timescale 1ns/1ps
module rx_bit_timer
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR       = RX_OSR,
  parameter int unsigned FRAME_MAX = RX_FRAME_MAX,
  parameter int unsigned SYNC      = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         line_in,
  input  logic [$clog2(FRAME_MAX+1)-1:0] nbits,
  output logic [FRAME_MAX-1:0]         frame_bits,
  output logic                         frame_done
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned IDX_W = $clog2(FRAME_MAX+1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);

  logic [SYNC-1:0]      sync_q;
  logic                 rx_s;
  rx_state_t            state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_MAX-1:0] bits_q, bits_d;
  logic                 done_q, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], line_in};
  end
  assign rx_s = sync_q[SYNC-1];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    bits_d  = bits_q;
    done_d  = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (!rx_s) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
      end
      RX_START: begin
        if (cnt_q == HALF_LAST) begin
          cnt_d = '0;
          if (!rx_s) begin
            state_d = RX_BITS;
            idx_d   = '0;
            bits_d  = '0;
          end else begin
            state_d = RX_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_BITS: begin
        if (cnt_q == FULL_LAST) begin
          cnt_d         = '0;
          bits_d[idx_q] = rx_s;
          if (idx_q == nbits - 1'b1) begin
            done_d  = 1'b1;
            state_d = RX_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      bits_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      bits_q  <= bits_d;
      done_q  <= done_d;
    end
  end

  assign frame_bits = bits_q;
  assign frame_done = done_q;
endmodule

// File: rtl/rx_frame_check.sv
`timescale 1ns/1ps
module rx_frame_check
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W    = RX_DATA_MAX,
  parameter int unsigned FRAME_MAX = RX_FRAME_MAX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rx_cfg_t              cfg,
  input  logic [FRAME_MAX-1:0] frame_bits,
  input  logic                 frame_done,
  input  logic                 dr_clr,
  output logic [DATA_W-1:0]    rbuf,
  output logic                 data_ready,
  output logic                 par_err,
  output logic                 frm_err,
  output logic                 ovr_err
);
  logic [DATA_W-1:0] data_v;
  logic              par_bad, frm_bad, par_exp;
  logic              stop_a, stop_b, par_rx;

  logic [DATA_W-1:0] rbuf_q, rbuf_d;
  logic              dr_q, dr_d, pe_q, pe_d, fe_q, fe_d, oe_q, oe_d;

  always_comb begin
    int nd;
    int sp;
    nd = int'(RX_DATA_MIN) + int'(cfg.len);
    for (int i = 0; i < int'(DATA_W); i++) begin
      data_v[i] = (i < nd) ? frame_bits[i] : 1'b0;
    end
    sp      = nd + (cfg.par_en ? 1 : 0);
    par_rx  = frame_bits[nd];
    stop_a  = frame_bits[sp];
    stop_b  = frame_bits[sp+1];
    par_exp = cfg.even ? (^data_v) : ~(^data_v);
    par_bad = cfg.par_en && (par_rx != par_exp);
    frm_bad = !stop_a || (cfg.two_stop && !stop_b);
  end

  always_comb begin
    rbuf_d = rbuf_q;
    pe_d   = pe_q;
    fe_d   = fe_q;
    oe_d   = oe_q;
    dr_d   = dr_q;
    if (dr_clr) dr_d = 1'b0;
    if (frame_done) begin
      rbuf_d = data_v;
      pe_d   = par_bad;
      fe_d   = frm_bad;
      oe_d   = dr_q;
      dr_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q <= '0;
      dr_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      rbuf_q <= rbuf_d;
      dr_q   <= dr_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      oe_q   <= oe_d;
    end
  end

  assign rbuf       = rbuf_q;
  assign data_ready = dr_q;
  assign par_err    = pe_q;
  assign frm_err    = fe_q;
  assign ovr_err    = oe_q;
endmodule

// File: rtl/uart_frame_rx.sv
`timescale 1ns/1ps
module uart_frame_rx
  import uart_rx_pkg::*;
(
  input  logic                   clk16,
  input  logic                   rst_n,
  input  logic                   ser_in,
  input  logic [RX_CFG_W-1:0]    ctl_word,
  input  logic                   ctl_load,
  input  logic                   dr_clr,
  output logic [RX_DATA_MAX-1:0] rbuf,
  output logic                   data_ready,
  output logic                   par_err,
  output logic                   frm_err,
  output logic                   ovr_err
);
  localparam int unsigned NB_W = $clog2(RX_FRAME_MAX+1);

  logic                    rst_sn;
  rx_cfg_t                 cfg;
  logic [NB_W-1:0]         nbits;
  logic [RX_FRAME_MAX-1:0] frame_bits;
  logic                    frame_done;

  rx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk16), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  rx_cfg_latch u_cfg (
    .clk(clk16), .rst_n(rst_sn), .ctl_word(ctl_word),
    .ctl_load(ctl_load), .cfg(cfg)
  );

  always_comb begin
    nbits = NB_W'(RX_DATA_MIN) + NB_W'(cfg.len) + NB_W'(cfg.par_en)
          + NB_W'(1) + NB_W'(cfg.two_stop);
  end

  rx_bit_timer #(.OSR(RX_OSR), .FRAME_MAX(RX_FRAME_MAX), .SYNC(2)) u_timer (
    .clk(clk16), .rst_n(rst_sn), .line_in(ser_in), .nbits(nbits),
    .frame_bits(frame_bits), .frame_done(frame_done)
  );

  rx_frame_check #(.DATA_W(RX_DATA_MAX), .FRAME_MAX(RX_FRAME_MAX)) u_check (
    .clk(clk16), .rst_n(rst_sn), .cfg(cfg), .frame_bits(frame_bits),
    .frame_done(frame_done), .dr_clr(dr_clr), .rbuf(rbuf),
    .data_ready(data_ready), .par_err(par_err), .frm_err(frm_err),
    .ovr_err(ovr_err)
  );
endmodule

// File: rtl/uart_frame_rx_chk.sv
`timescale 1ns/1ps
module uart_frame_rx_chk (
  input logic       clk,
  input logic       rst_sn,
  input logic       frame_done,
  input logic [1:0] cfg_len,
  input logic       dr_clr,
  input logic [7:0] rbuf,
  input logic       data_ready,
  input logic       par_err,
  input logic       frm_err,
  input logic       ovr_err
);
  // R6
  dr_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_done |=> data_ready);
  // R6
  dr_clr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (dr_clr && !frame_done) |=> !data_ready);
  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (frame_done && data_ready) |=> ovr_err);
  // R9
  ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (frame_done && !data_ready) |=> !ovr_err);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !frame_done |=> ($stable(rbuf) && $stable(par_err) && $stable(frm_err) && $stable(ovr_err)));
  // R5
  pad_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (frame_done && cfg_len == 2'b00) |=> (rbuf[7:5] == 3'b000));
endmodule

bind uart_frame_rx uart_frame_rx_chk i_chk (
  .clk(clk16), .rst_sn(rst_sn), .frame_done(frame_done), .cfg_len(cfg.len),
  .dr_clr(dr_clr), .rbuf(rbuf), .data_ready(data_ready), .par_err(par_err),
  .frm_err(frm_err), .ovr_err(ovr_err)
);

// File: tb/test_uart_frame_rx.sv
`timescale 1ns/1ps
module test_uart_frame_rx;
  logic       clk16 = 1'b0;
  logic       rst_n;
  logic       ser_in;
  logic [4:0] ctl_word;
  logic       ctl_load;
  logic       dr_clr;
  logic [7:0] rbuf;
  logic       data_ready, par_err, frm_err, ovr_err;
  int total = 0;
  int bad   = 0;

  always #2 clk16 = ~clk16;

  uart_frame_rx i_uart_frame_rx (
    .clk16(clk16), .rst_n(rst_n), .ser_in(ser_in), .ctl_word(ctl_word),
    .ctl_load(ctl_load), .dr_clr(dr_clr), .rbuf(rbuf), .data_ready(data_ready),
    .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk16);
      ser_in = v;
    end
  endtask

  task automatic set_cfg(input logic [4:0] w);
    @(negedge clk16);
    ctl_word = w;
    ctl_load = 1'b1;
    @(negedge clk16);
    ctl_load = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk16);
    dr_clr = 1'b1;
    @(negedge clk16);
    dr_clr = 1'b0;
  endtask

  // word: {even, par_en, two_stop, len}
  task automatic send(input logic [7:0] d, input int nd, input logic pe, input logic ev,
                      input logic two, input logic flip_par, input logic bad_s1,
                      input logic bad_s2);
    logic [7:0] m;
    logic p;
    m = d & 8'((1 << nd) - 1);
    drive(1'b0, 16);
    for (int i = 0; i < nd; i++) drive(d[i], 16);
    if (pe) begin
      p = ev ? (^m) : ~(^m);
      drive(p ^ flip_par, 16);
    end
    if (two) begin
      drive(!bad_s1, 16);
      if (bad_s2) begin drive(1'b0, 10); drive(1'b1, 6); end
      else drive(1'b1, 16);
    end else begin
      if (bad_s1) begin drive(1'b0, 10); drive(1'b1, 6); end
      else drive(1'b1, 16);
    end
    drive(1'b1, 6);
  endtask

  task automatic t_reset();
    chk("R1", "rbuf", rbuf, 0);
    chk("R1", "data_ready", data_ready, 0);
    chk("R1", "errors", {par_err, frm_err, ovr_err}, 0);
  endtask

  task automatic t_basic8();
    set_cfg(5'b00011);
    send(8'hA5, 8, 0, 0, 0, 0, 0, 0);
    chk("R4", "rbuf 8N1", rbuf, 8'hA5);
    chk("R6", "data_ready set", data_ready, 1);
    chk("R7", "par_err none", par_err, 0);
    chk("R8", "frm_err none", frm_err, 0);
    ack();
    drive(1'b1, 2);
    chk("R6", "data_ready cleared", data_ready, 0);
    chk("R10", "rbuf held after ack", rbuf, 8'hA5);
  endtask

  task automatic t_pad5();
    set_cfg(5'b00000);
    send(8'hF5, 5, 0, 0, 0, 0, 0, 0);
    chk("R5", "rbuf 5-bit padded", rbuf, 8'h15);
    chk("R8", "frm_err 5N1", frm_err, 0);
    ack();
    set_cfg(5'b00001);
    send(8'h2B, 6, 0, 0, 0, 0, 0, 0);
    chk("R5", "rbuf 6-bit", rbuf, 8'h2B);
    ack();
  endtask

  task automatic t_parity();
    set_cfg(5'b11010);  // 7 bits, even parity
    send(8'h5B, 7, 1, 1, 0, 0, 0, 0);
    chk("R7", "even good", par_err, 0);
    chk("R4", "rbuf 7E1", rbuf, 8'h5B);
    ack();
    send(8'h5B, 7, 1, 1, 0, 1, 0, 0);
    chk("R7", "even flipped", par_err, 1);
    ack();
    set_cfg(5'b01011);  // 8 bits, odd parity
    send(8'h3C, 8, 1, 0, 0, 0, 0, 0);
    chk("R7", "odd good", par_err, 0);
    chk("R8", "frm 8O1", frm_err, 0);
    ack();
    send(8'h3C, 8, 1, 0, 0, 1, 0, 0);
    chk("R7", "odd flipped", par_err, 1);
    ack();
  endtask

  task automatic t_framing();
    set_cfg(5'b00011);
    send(8'h81, 8, 0, 0, 0, 0, 1, 0);
    chk("R8", "one stop low", frm_err, 1);
    chk("R4", "rbuf with bad stop", rbuf, 8'h81);
    ack();
    set_cfg(5'b00111);  // 8 bits, two stops
    send(8'h66, 8, 0, 0, 1, 0, 0, 0);
    chk("R8", "two stops good", frm_err, 0);
    ack();
    send(8'h66, 8, 0, 0, 1, 0, 0, 1);
    chk("R8", "second stop low", frm_err, 1);
    ack();
    send(8'h66, 8, 0, 0, 1, 0, 1, 0);
    chk("R8", "first stop low", frm_err, 1);
    ack();
  endtask

  task automatic t_overrun();
    set_cfg(5'b00011);
    send(8'h11, 8, 0, 0, 0, 0, 0, 0);
    chk("R9", "no overrun first", ovr_err, 0);
    send(8'h22, 8, 0, 0, 0, 0, 0, 0);
    chk("R9", "overrun set", ovr_err, 1);
    chk("R9", "rbuf replaced", rbuf, 8'h22);
    ack();
    drive(1'b1, 2);
    chk("R10", "ovr held after ack", ovr_err, 1);
    send(8'h33, 8, 0, 0, 0, 0, 0, 0);
    chk("R9", "overrun cleared", ovr_err, 0);
    chk("R4", "rbuf third", rbuf, 8'h33);
    ack();
  endtask

  task automatic t_false_start();
    drive(1'b0, 5);
    drive(1'b1, 200);
    chk("R3", "glitch ignored dr", data_ready, 0);
    chk("R3", "glitch ignored rbuf", rbuf, 8'h33);
    send(8'hC3, 8, 0, 0, 0, 0, 0, 0);
    chk("R3", "frame after glitch", rbuf, 8'hC3);
    ack();
  endtask

  task automatic t_cfg_ignore();
    set_cfg(5'b00011);
    @(negedge clk16);
    ctl_word = 5'b00000;  // load low: ignored
    drive(1'b1, 4);
    send(8'hE7, 8, 0, 0, 0, 0, 0, 0);
    chk("R2", "word ignored without load", rbuf, 8'hE7);
    chk("R2", "frm with old format", frm_err, 0);
    ack();
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_in = 1'b1; ctl_word = 5'b0; ctl_load = 1'b0; dr_clr = 1'b0;
    drive(1'b1, 3);
    t_reset();
    rst_n = 1'b1;
    drive(1'b1, 8);
    t_reset();
    t_basic8();
    t_pad5();
    t_parity();
    t_framing();
    t_overrun();
    t_false_start();
    t_cfg_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule